// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the ring of boundary cells that sits between a chip's core logic and its pins. Every functional input pin has one cell. Every functional output pin has a pair of cells: a data cell, and next to it a control cell that holds that pin's output enable. Each cell has two stages. The capture/shift stage changes on the rising test-clock edge. The update stage changes on the falling test-clock edge. An external test-port state machine supplies the test clock, the serial input, and the capture, shift and update strobes. An external instruction decoder supplies five flags: sample, extest, intest, clamp and highz.

The five flags set the active test mode. This mode is held in an enumerated register that changes on the falling test-clock edge. The mode controls three things: whether the pins and core see each other directly or see the update stages, whether the output enables are forced off, and whether the serial output comes from the end of the chain or from a one-bit bypass register. The test logic runs entirely on the test clock, which may run at a different rate from the system clock. An optional asynchronous test reset returns every stage and the mode register to a harmless state.

Top module: `bsr_chain`

## Requirements
- R1: While `trst_n` is low, the mode is functional, and all shift, update and bypass stages are zero. As a result, `tdo` is 0 and the pins and core pass through. The reset acts without a clock edge.
- R2: In functional mode (no flag set), `pin_out`=`core_out`, `pin_oe`=`core_oe` and `core_in`=`pin_in`. The update stages have no effect on these outputs.
- R3: The mode is chosen by priority: highz over clamp, over intest, over extest, over sample, over functional. Flags that change take effect at the next falling `tck` edge.
- R4: A capture strobe, in sample, extest or intest mode, loads the cells on the next rising edge. Cell i (i < NUM_IN) takes `pin_in[i]`. Cell NUM_IN+2k takes `core_out[k]`. Cell NUM_IN+2k+1 takes `core_oe[k]`. In sample mode, the pins and core are not disturbed.
- R5: With the shift strobe in a chain mode, each rising edge moves data one cell toward `tdo`. Cell 0 loads `tdi`, and `tdo` shows the last cell. Capture wins over shift when both strobes are high.
- R6: The update stages load from the shift stages only on the update strobe, at the falling `tck` edge. Data preloaded in one mode is kept for a later mode.
- R7: In extest mode, `pin_out[k]` and `pin_oe[k]` come from the update stages of cells NUM_IN+2k and NUM_IN+2k+1, and `core_in` follows `pin_in`.
- R8: In intest mode, `core_in[i]` comes from the update stage of cell i, and the pins are driven from the update stages as in extest.
- R9: In clamp mode, the pins are driven from the update stages and `core_in` follows `pin_in`. `tdo` comes from the bypass bit, which loads 0 on capture and `tdi` on shift. The chain cells hold their values in this mode. Functional mode uses the same bypass path.
- R10: In highz mode, every `pin_oe` bit is 0 and the serial path goes through the bypass bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| ins_sample | input | 1 | Sample/preload instruction flag |
| ins_extest | input | 1 | External test flag |
| ins_intest | input | 1 | Internal test flag |
| ins_clamp | input | 1 | Clamp flag |
| ins_highz | input | 1 | Float-all-outputs flag |
| pin_in | input | NUM_IN | Values arriving at input pins |
| core_in | output | NUM_IN | Values presented to the core |
| core_out | input | NUM_OUT | Core output data |
| core_oe | input | NUM_OUT | Core output enables |
| pin_out | output | NUM_OUT | Data driven toward the output pads |
| pin_oe | output | NUM_OUT | Per-pin output enables |
| tdo | output | 1 | Serial test data out |

## Verification
On every cycle, the assertions check the following. Reset forces `tdo` low. Functional mode and extest pass values straight through. Highz keeps every enable at zero. A bypass capture clears `tdo`. Pin drive stays steady in extest whenever no update strobe arrives. Other behaviour can only be shown by the bench scenarios: the exact bit order of the captured pattern shifted out serially, capture winning over shift, preloaded data surviving a mode change, the chain holding its contents while clamp routes traffic through bypass, and the half-cycle delay between a flag change or an update strobe and its effect on the pins.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [2:0] {
        M_FUNC   = 3'd0,
        M_SAMPLE = 3'd1,
        M_EXTEST = 3'd2,
        M_INTEST = 3'd3,
        M_CLAMP  = 3'd4,
        M_HIGHZ  = 3'd5
    } bsr_mode_e;

    // Priority decode of the instruction flags into a single mode.
    function automatic bsr_mode_e decode_mode(
        input logic sample,
        input logic extest,
        input logic intest,
        input logic clamp,
        input logic highz
    );
        if (highz)       return M_HIGHZ;
        else if (clamp)  return M_CLAMP;
        else if (intest) return M_INTEST;
        else if (extest) return M_EXTEST;
        else if (sample) return M_SAMPLE;
        else             return M_FUNC;
    endfunction

endpackage

// File: rtl/bsr_mode_fsm.sv
module bsr_mode_fsm
    import bsr_pkg::*;
(
    input  logic      tck,
    input  logic      trst_n,
    input  logic      ins_sample,
    input  logic      ins_extest,
    input  logic      ins_intest,
    input  logic      ins_clamp,
    input  logic      ins_highz,
    output bsr_mode_e mode_q,
    output logic      chain_sel,
    output logic      pins_from_upd,
    output logic      oe_kill,
    output logic      core_from_upd
);

    bsr_mode_e mode_d;

    always_comb begin
        mode_d = decode_mode(ins_sample, ins_extest, ins_intest, ins_clamp, ins_highz);
    end

    // Mode changes on the falling edge, alongside the update stages.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) mode_q <= M_FUNC;
        else         mode_q <= mode_d;
    end

    always_comb begin
        chain_sel     = 1'b0;
        pins_from_upd = 1'b0;
        oe_kill       = 1'b0;
        core_from_upd = 1'b0;
        unique case (mode_q)
            M_FUNC: begin
            end
            M_SAMPLE: begin
                chain_sel = 1'b1;
            end
            M_EXTEST: begin
                chain_sel     = 1'b1;
                pins_from_upd = 1'b1;
            end
            M_INTEST: begin
                chain_sel     = 1'b1;
                pins_from_upd = 1'b1;
                core_from_upd = 1'b1;
            end
            M_CLAMP: begin
                pins_from_upd = 1'b1;
            end
            M_HIGHZ: begin
                pins_from_upd = 1'b1;
                oe_kill       = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell (
    input  logic tck,
    input  logic trst_n,
    input  logic cap_en,
    input  logic sh_en,
    input  logic upd_en,
    input  logic cap_d,
    input  logic scan_in,
    output logic shift_q,
    output logic upd_q
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     shift_q <= 1'b0;
        else if (cap_en) shift_q <= cap_d;
        else if (sh_en)  shift_q <= scan_in;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)     upd_q <= 1'b0;
        else if (upd_en) upd_q <= shift_q;
    end

endmodule

// File: rtl/bsr_bypass.sv
module bsr_bypass (
    input  logic tck,
    input  logic trst_n,
    input  logic sel,
    input  logic capture,
    input  logic shift,
    input  logic tdi,
    output logic byp_q
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)              byp_q <= 1'b0;
        else if (sel && capture)  byp_q <= 1'b0;
        else if (sel && shift)    byp_q <= tdi;
    end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               ins_sample,
    input  logic               ins_extest,
    input  logic               ins_intest,
    input  logic               ins_clamp,
    input  logic               ins_highz,
    input  logic [NUM_IN-1:0]  pin_in,
    output logic [NUM_IN-1:0]  core_in,
    input  logic [NUM_OUT-1:0] core_out,
    input  logic [NUM_OUT-1:0] core_oe,
    output logic [NUM_OUT-1:0] pin_out,
    output logic [NUM_OUT-1:0] pin_oe,
    output logic               tdo
);

    localparam int LEN      = NUM_IN + 2 * NUM_OUT;
    localparam int OUT_BASE = NUM_IN;

    bsr_mode_e mode_q;
    logic      chain_sel, pins_from_upd, oe_kill, core_from_upd;
    logic      cap_en, sh_en, upd_en, byp_q;

    logic [LEN-1:0] shift_q, upd_q, cap_vec, scan_in_v;

    bsr_mode_fsm u_fsm (
        .tck           (tck),
        .trst_n        (trst_n),
        .ins_sample    (ins_sample),
        .ins_extest    (ins_extest),
        .ins_intest    (ins_intest),
        .ins_clamp     (ins_clamp),
        .ins_highz     (ins_highz),
        .mode_q        (mode_q),
        .chain_sel     (chain_sel),
        .pins_from_upd (pins_from_upd),
        .oe_kill       (oe_kill),
        .core_from_upd (core_from_upd)
    );

    assign cap_en    = capture_dr & chain_sel;
    assign sh_en     = shift_dr & chain_sel;
    assign upd_en    = update_dr & chain_sel;
    assign scan_in_v = {shift_q[LEN-2:0], tdi};

    // Capture sources: input pins first, then data/enable pairs.
    genvar gi, gk, gj;
    generate
        for (gi = 0; gi < NUM_IN; gi++) begin : g_in_cap
            assign cap_vec[gi] = pin_in[gi];
        end
        for (gk = 0; gk < NUM_OUT; gk++) begin : g_out_cap
            assign cap_vec[OUT_BASE + 2*gk]     = core_out[gk];
            assign cap_vec[OUT_BASE + 2*gk + 1] = core_oe[gk];
        end
        for (gj = 0; gj < LEN; gj++) begin : g_cell
            bsr_cell u_cell (
                .tck     (tck),
                .trst_n  (trst_n),
                .cap_en  (cap_en),
                .sh_en   (sh_en),
                .upd_en  (upd_en),
                .cap_d   (cap_vec[gj]),
                .scan_in (scan_in_v[gj]),
                .shift_q (shift_q[gj]),
                .upd_q   (upd_q[gj])
            );
        end
    endgenerate

    bsr_bypass u_byp (
        .tck     (tck),
        .trst_n  (trst_n),
        .sel     (~chain_sel),
        .capture (capture_dr),
        .shift   (shift_dr),
        .tdi     (tdi),
        .byp_q   (byp_q)
    );

    always_comb begin
        for (int k = 0; k < NUM_OUT; k++) begin
            pin_out[k] = pins_from_upd ? upd_q[OUT_BASE + 2*k] : core_out[k];
            if (oe_kill)            pin_oe[k] = 1'b0;
            else if (pins_from_upd) pin_oe[k] = upd_q[OUT_BASE + 2*k + 1];
            else                    pin_oe[k] = core_oe[k];
        end
        for (int i = 0; i < NUM_IN; i++) begin
            core_in[i] = core_from_upd ? upd_q[i] : pin_in[i];
        end
        tdo = chain_sel ? shift_q[LEN-1] : byp_q;
    end

endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk
    import bsr_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4
) (
    input logic               tck,
    input logic               trst_n,
    input logic               capture_dr,
    input logic               update_dr,
    input logic               ins_sample,
    input logic               ins_extest,
    input logic               ins_intest,
    input logic               ins_clamp,
    input logic               ins_highz,
    input logic [NUM_IN-1:0]  pin_in,
    input logic [NUM_IN-1:0]  core_in,
    input logic [NUM_OUT-1:0] core_out,
    input logic [NUM_OUT-1:0] core_oe,
    input logic [NUM_OUT-1:0] pin_out,
    input logic [NUM_OUT-1:0] pin_oe,
    input logic               tdo,
    input bsr_mode_e          mode_q
);

    logic no_flag, extest_only, byp_mode;
    assign no_flag     = !(ins_sample | ins_extest | ins_intest | ins_clamp | ins_highz);
    assign extest_only = ins_extest & !ins_intest & !ins_clamp & !ins_highz;
    assign byp_mode    = (mode_q == M_FUNC) || (mode_q == M_CLAMP) || (mode_q == M_HIGHZ);

    assert_reset_tdo_R1: assert property (@(posedge tck) !trst_n |-> (tdo == 1'b0));

    assert_func_pass_R2: assert property (@(negedge tck) disable iff (!trst_n)
        no_flag |=> (pin_out == core_out && pin_oe == core_oe && core_in == pin_in));

    assert_extest_core_R7: assert property (@(negedge tck) disable iff (!trst_n)
        extest_only |=> (core_in == pin_in));

    assert_update_hold_R6: assert property (@(negedge tck) disable iff (!trst_n)
        (mode_q == M_EXTEST && extest_only && !update_dr) |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_bypass_cap_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (byp_mode && capture_dr) |=> (!byp_mode || tdo == 1'b0));

    assert_highz_float_R10: assert property (@(negedge tck) disable iff (!trst_n)
        ins_highz |=> (pin_oe == '0));

endmodule

bind bsr_chain bsr_chain_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .capture_dr (capture_dr),
    .update_dr  (update_dr),
    .ins_sample (ins_sample),
    .ins_extest (ins_extest),
    .ins_intest (ins_intest),
    .ins_clamp  (ins_clamp),
    .ins_highz  (ins_highz),
    .pin_in     (pin_in),
    .core_in    (core_in),
    .core_out   (core_out),
    .core_oe    (core_oe),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .tdo        (tdo),
    .mode_q     (mode_q)
);

// File: tb/bsr_chain_tb.sv
module bsr_chain_tb;

    localparam int NI  = 4;
    localparam int NO  = 4;
    localparam int LEN = NI + 2 * NO;

    logic tck = 1'b0;
    always #4 tck = ~tck;

    logic trst_n = 1'b1;
    logic tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic [4:0] flags = '0;   // {highz, clamp, intest, extest, sample}
    logic [NI-1:0] pin_in = '0;
    logic [NO-1:0] core_out = '0, core_oe = '0;
    logic [NI-1:0] core_in;
    logic [NO-1:0] pin_out, pin_oe;
    logic tdo;

    int n_chk = 0;
    int n_fail = 0;

    bsr_chain #(.NUM_IN(NI), .NUM_OUT(NO)) u_dut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .ins_sample(flags[0]), .ins_extest(flags[1]), .ins_intest(flags[2]),
        .ins_clamp(flags[3]), .ins_highz(flags[4]),
        .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .core_oe(core_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .tdo(tdo)
    );

    typedef struct packed {
        logic [4:0]    fl;
        logic [NI-1:0] pi;
        logic [NO-1:0] co;
        logic [NO-1:0] coe;
        logic [NO-1:0] epo;
        logic [NO-1:0] epoe;
        logic [NI-1:0] eci;
    } vec_t;

    // Preload held in update stages: in=1010, data=0110, enable=1011.
    localparam vec_t VECS [9] = '{
        '{5'b00000, 4'b0101, 4'b1100, 4'b1111, 4'b1100, 4'b1111, 4'b0101},
        '{5'b00001, 4'b0101, 4'b1100, 4'b1111, 4'b1100, 4'b1111, 4'b0101},
        '{5'b00010, 4'b0011, 4'b1100, 4'b0111, 4'b0110, 4'b1011, 4'b0011},
        '{5'b00100, 4'b0011, 4'b1100, 4'b0111, 4'b0110, 4'b1011, 4'b1010},
        '{5'b01000, 4'b1111, 4'b0000, 4'b0000, 4'b0110, 4'b1011, 4'b1111},
        '{5'b10000, 4'b1001, 4'b0000, 4'b1111, 4'b0110, 4'b0000, 4'b1001},
        '{5'b10010, 4'b1001, 4'b1100, 4'b1111, 4'b0110, 4'b0000, 4'b1001},
        '{5'b01100, 4'b0110, 4'b1100, 4'b1111, 4'b0110, 4'b1011, 4'b0110},
        '{5'b00000, 4'b1110, 4'b1010, 4'b0101, 4'b1010, 4'b0101, 4'b1110}
    };
    localparam string VREQ [9] = '{"R2", "R6", "R7", "R8", "R9", "R10", "R3", "R3", "R2"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [LEN-1:0] pack(input logic [NI-1:0] i, input logic [NO-1:0] d,
                                             input logic [NO-1:0] e);
        logic [LEN-1:0] v;
        for (int a = 0; a < NI; a++) v[a] = i[a];
        for (int k = 0; k < NO; k++) begin
            v[NI + 2*k]     = d[k];
            v[NI + 2*k + 1] = e[k];
        end
        return v;
    endfunction

    // Align to 1 ns after a rising edge.
    task automatic step();
        @(posedge tck);
        #1;
    endtask

    task automatic shift_chain(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
        shift_dr = 1'b1;
        for (int s = 0; s < LEN; s++) begin
            tdi = din[LEN-1-s];
            #4;
            dout[LEN-1-s] = tdo;
            step();
        end
        shift_dr = 1'b0;
    endtask

    task automatic do_capture();
        capture_dr = 1'b1;
        step();
        capture_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        @(negedge tck);
        #1;
        update_dr = 1'b0;
        step();
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [LEN-1:0] got;
        #1 trst_n = 1'b0;
        pin_in = 4'hA; core_out = 4'h5; core_oe = 4'h3;
        #20;
        // R1 reset state
        chk("R1 tdo", tdo, 0);
        chk("R1 pin_out", pin_out, 4'h5);
        chk("R1 pin_oe", pin_oe, 4'h3);
        chk("R1 core_in", core_in, 4'hA);
        step();
        trst_n = 1'b1;
        step();

        // Preload under sample (R6)
        flags = 5'b00001;
        step();
        shift_chain(pack(4'b1010, 4'b0110, 4'b1011), got);
        do_update();
        chk("R6 sample untouched", pin_out, 4'h5);

        // Table walk
        for (int v = 0; v < 9; v++) begin
            flags = VECS[v].fl; pin_in = VECS[v].pi;
            core_out = VECS[v].co; core_oe = VECS[v].coe;
            #4;
            chk({VREQ[v], " pin_out"}, pin_out, VECS[v].epo);
            chk({VREQ[v], " pin_oe"},  pin_oe,  VECS[v].epoe);
            chk({VREQ[v], " core_in"}, core_in, VECS[v].eci);
            step();
        end

        // R4 / R5: sample capture then serial readout
        flags = 5'b00001; pin_in = 4'b1100; core_out = 4'b1001; core_oe = 4'b0110;
        step();
        do_capture();
        shift_chain('0, got);
        chk("R4 captured pattern", got, pack(4'b1100, 4'b1001, 4'b0110));
        chk("R4 sample pins undisturbed", pin_out, 4'b1001);
        chk("R5 tdo after zero fill", tdo, 0);

        // R5 capture wins over shift
        core_oe = 4'b1000;
        capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1;
        step();
        capture_dr = 1'b0; shift_dr = 1'b0; tdi = 1'b0;
        #4;
        chk("R5 capture over shift", tdo, 1);
        step();

        // R6 update only on strobe, at falling edge
        flags = 5'b00010;
        step();
        shift_chain(pack(4'b0000, 4'b1001, 4'b1111), got);
        chk("R6 no update pin_out", pin_out, 4'b0110);
        chk("R6 no update pin_oe", pin_oe, 4'b1011);
        update_dr = 1'b1;
        #1;
        chk("R6 before falling edge", pin_out, 4'b0110);
        @(negedge tck);
        #1;
        update_dr = 1'b0;
        chk("R6 after falling edge", pin_out, 4'b1001);
        chk("R7 extest enables", pin_oe, 4'b1111);
        step();

        // R8 intest: core fed from update, capture core responses
        flags = 5'b00100; pin_in = 4'b1111; core_out = 4'b0101; core_oe = 4'b0011;
        step();
        chk("R8 core_in from update", core_in, 4'b0000);
        do_capture();

        // R9 clamp: bypass path, chain holds
        flags = 5'b01000;
        step();
        chk("R9 clamp pin_out", pin_out, 4'b1001);
        do_capture();
        #4;
        chk("R9 bypass capture zero", tdo, 0);
        step();
        shift_dr = 1'b1; tdi = 1'b1;
        step();
        #4;
        chk("R9 bypass shift one", tdo, 1);
        step();
        tdi = 1'b0;
        step();
        shift_dr = 1'b0;
        #4;
        chk("R9 bypass shift zero", tdo, 0);
        step();
        flags = 5'b00010;
        step();
        shift_chain('0, got);
        chk("R9 chain held during clamp", got, pack(4'b1111, 4'b0101, 4'b0011));

        // R3 flag change waits for falling edge; R10 bypass in highz
        flags = 5'b10000;
        #1;
        chk("R3 before falling edge", pin_oe, 4'b1111);
        #3;
        chk("R10 highz enables", pin_oe, 4'b0000);
        step();

        // R1 asynchronous reset mid-run
        flags = 5'b00010; core_out = 4'b0110; core_oe = 4'b1010;
        step();
        trst_n = 1'b0;
        #1;
        chk("R1 async pin_oe", pin_oe, 4'b1010);
        chk("R1 async tdo", tdo, 0);
        trst_n = 1'b1;
        step();
        chk("R1 update cleared", pin_out, 4'b0000);
        chk("R1 enables cleared", pin_oe, 4'b0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule